// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 interrupt request lines into one bank and presents two processor interrupt outputs, a normal one (`irq_n`) and a fast one (`fiq_n`), both active low. Each source has its own configuration word that picks which output it drives, whether it is sensed by level or by rising edge, and a 5-bit priority. Requests are latched into a pending register. A mask register then filters them, and one arbiter per output picks the best remaining request.

Each arbiter latches its winner and holds it until software writes the matching acknowledge bit in the control register. The interrupt handler can therefore read a source number that stays stable while it services that source. The acknowledge also clears the winner's pending bit when that source is edge-sensed. Arbitration restarts on the next cycle.

Software reaches the block through a single-cycle write strobe, a byte address and a combinational read port. Addresses are decoded on whole 32-bit words.

Top module: `intc_bank`

## Requirements
- R1: After a synchronous reset, every mask bit is 1, the pending register is 0, all source configuration words are 0, both source-number registers read 0, and `irq_n` and `fiq_n` are high.
- R2: The configuration word of source n is at address 0x80 + 4*n. Bit 0 = 1 sends the source to the fast output, bit 1 = 1 selects edge sensing (0 selects level), and bits 6:2 hold the priority. Reads return those 7 bits, and all higher bits read 0.
- R3: The mask register is at 0x04. A 1 in bit n keeps source n out of arbitration. Its pending bit stays visible in the pending register at 0x00.
- R4: For a level-sensed source, the pending bit equals the input as sampled on the previous clock edge.
- R5: For an edge-sensed source, a rising input sets the pending bit. The bit stays set after the input falls, until it is cleared by R6 or R9.
- R6: A write to the pending register ANDs the written data into the edge-latched bits, so writing 0 clears every latched request.
- R7: Among unmasked pending sources routed to an output, the lowest priority value wins, and a tie goes to the lower source number. The two outputs arbitrate independently. A winner is latched one cycle after its request becomes eligible.
- R8: Once a winner is latched, the output and its source-number register hold, even if the source deasserts or a better request arrives.
- R9: A write to the control register at 0x10 releases the normal winner when bit 0 is set and the fast winner when bit 1 is set. The released winner's edge-latched pending bit is cleared, and a new winner can be latched on the following cycle.
- R10: The normal source register (0x08) and the fast source register (0x0C) read the held winner number, or 0 when no winner is held. Each output is low exactly while its arbiter holds a winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Interrupt request lines, synchronous to clk |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_n | output | 1 | Normal interrupt, active low |
| fiq_n | output | 1 | Fast interrupt, active low |

## Verification
The assertions assume that `src_in` is already synchronous to `clk`, so a rising edge is the change between two sampled values. They also assume that every register access is a whole-cycle strobe with a word-aligned address. The stimulus changes `src_in` and the bus signals only on the falling clock edge and holds each value for full cycles. Random rounds draw route, priority and request patterns from a fixed seed. Each round masks all sources while it reconfigures, so no stale winner carries into the checked sequence of winners.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC   = 32;
    localparam int PRIO_W = 5;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NPATH  = 2;

    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQ_SRC = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FIQ_SRC = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h80;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              edge_mode;
        logic              to_fiq;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);

    typedef enum logic {PATH_IRQ = 1'b0, PATH_FIQ = 1'b1} path_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] id;
    } win_t;

    function automatic logic word_hit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] o);
        return a[ADDR_W-1:2] == o[ADDR_W-1:2];
    endfunction

    function automatic logic [DATA_W-1:0] win_word(win_t w);
        return w.valid ? DATA_W'(w.id) : '0;
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] edge_sel,
    input  logic         pend_wr,
    input  logic [N-1:0] pend_wdata,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] keep;

    assign rise = src_in & ~prev_q;
    assign keep = pend_wr ? pend_wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= src_in;
            for (int i = 0; i < N; i++) begin
                if (edge_sel[i])
                    pend_q[i] <= (pend_q[i] & keep[i] & ~ack_clr[i]) | rise[i];
                else
                    pend_q[i] <= src_in[i];
            end
        end
    end

    // R4: level-sensed bits track the input one edge later
    a_r4_level_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q ^ $past(src_in)) & $past(edge_sel ^ '1)) == '0);

    // R5: latched edge bits survive when nothing clears them
    a_r5_edge_holds: assert property (@(posedge clk) disable iff (rst)
        (!pend_wr && ack_clr == '0) |=> (($past(pend_q) & $past(edge_sel) & ~pend_q) == '0));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N  = 32,
    parameter int PW = 5,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N*PW-1:0] prio_flat,
    input  logic          release_i,
    output logic          valid_o,
    output logic [IW-1:0] id_o
);
    logic          found_c;
    logic [PW-1:0] best_p_c;
    logic [IW-1:0] best_id_c;

    always_comb begin
        found_c   = 1'b0;
        best_p_c  = '1;
        best_id_c = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found_c || prio_flat[i*PW +: PW] < best_p_c)) begin
                found_c   = 1'b1;
                best_p_c  = prio_flat[i*PW +: PW];
                best_id_c = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            id_o    <= '0;
        end else if (release_i) begin
            valid_o <= 1'b0;
        end else if (!valid_o && found_c) begin
            valid_o <= 1'b1;
            id_o    <= best_id_c;
        end
    end

    // R8: a held winner does not move until released
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !release_i) |=> (valid_o && $stable(id_o)));

    // R9: a release drops the held winner
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        release_i |=> !valid_o);

    // R7: an idle arbiter with a request latches on the next edge
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !release_i && req != '0) |=> valid_o);

    // R7: nothing is latched without a request
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && req == '0) |=> !valid_o);

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n,
    output logic              fiq_n
);
    localparam int CFG_SPAN = NSRC * 4;

    logic [NSRC-1:0]        mask_q;
    logic [NSRC-1:0]        pend;
    logic [NSRC-1:0]        active;
    logic [NSRC-1:0]        route_fiq;
    logic [NSRC-1:0]        edge_sel;
    logic [NSRC-1:0]        ack_clr;
    logic [NSRC*PRIO_W-1:0] prio_flat;
    src_cfg_t               cfg_q [NSRC];

    logic              wr_pend, wr_mask, wr_ctrl, hit_cfg;
    logic [ADDR_W-1:0] cfg_off;
    logic [SRC_W-1:0]  cfg_idx;

    logic [NSRC-1:0]   path_req   [NPATH];
    logic              path_rel   [NPATH];
    logic              path_valid [NPATH];
    logic [SRC_W-1:0]  path_id    [NPATH];
    win_t              irq_win, fiq_win;

    assign cfg_off = bus_addr - OFS_CFG;
    assign hit_cfg = (bus_addr >= OFS_CFG) && (int'(cfg_off) < CFG_SPAN);
    assign cfg_idx = SRC_W'(cfg_off >> 2);
    assign wr_pend = bus_we && word_hit(bus_addr, OFS_PEND);
    assign wr_mask = bus_we && word_hit(bus_addr, OFS_MASK);
    assign wr_ctrl = bus_we && word_hit(bus_addr, OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (wr_mask) mask_q <= bus_wdata[NSRC-1:0];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[s] <= '0;
            else if (bus_we && hit_cfg && cfg_idx == SRC_W'(s))
                cfg_q[s] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
        assign route_fiq[s]                  = cfg_q[s].to_fiq;
        assign edge_sel[s]                   = cfg_q[s].edge_mode;
        assign prio_flat[s*PRIO_W +: PRIO_W] = cfg_q[s].prio;
    end

    intc_capture #(.N(NSRC)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .src_in     (src_in),
        .edge_sel   (edge_sel),
        .pend_wr    (wr_pend),
        .pend_wdata (bus_wdata[NSRC-1:0]),
        .ack_clr    (ack_clr),
        .pend_q     (pend)
    );

    assign active = pend & ~mask_q;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        assign path_req[g] = active & ((g == int'(PATH_FIQ)) ? route_fiq : ~route_fiq);
        assign path_rel[g] = wr_ctrl && bus_wdata[g];

        intc_arbiter #(.N(NSRC), .PW(PRIO_W)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (path_req[g]),
            .prio_flat (prio_flat),
            .release_i (path_rel[g]),
            .valid_o   (path_valid[g]),
            .id_o      (path_id[g])
        );
    end

    always_comb begin
        ack_clr = '0;
        for (int g = 0; g < NPATH; g++)
            if (path_rel[g] && path_valid[g])
                ack_clr = ack_clr | (NSRC'(1) << path_id[g]);
    end

    assign irq_win = '{valid: path_valid[PATH_IRQ], id: path_id[PATH_IRQ]};
    assign fiq_win = '{valid: path_valid[PATH_FIQ], id: path_id[PATH_FIQ]};
    assign irq_n   = ~irq_win.valid;
    assign fiq_n   = ~fiq_win.valid;

    always_comb begin
        bus_rdata = '0;
        if (hit_cfg)                            bus_rdata = DATA_W'(cfg_q[cfg_idx]);
        else if (word_hit(bus_addr, OFS_PEND))    bus_rdata = DATA_W'(pend);
        else if (word_hit(bus_addr, OFS_MASK))    bus_rdata = DATA_W'(mask_q);
        else if (word_hit(bus_addr, OFS_IRQ_SRC)) bus_rdata = win_word(irq_win);
        else if (word_hit(bus_addr, OFS_FIQ_SRC)) bus_rdata = win_word(fiq_win);
    end

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && fiq_n && mask_q == '1 && pend == '0));

    // R9: an acknowledge write on bit 0 raises irq_n on the next edge
    a_r9_irq_ack: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[0]) |=> irq_n);

    // R9: an acknowledge write on bit 1 raises fiq_n on the next edge
    a_r9_fiq_ack: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[1]) |=> fiq_n);

    // R3: a fully masked bank never raises an output
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_n && fiq_n && mask_q == '1) |=> (irq_n && fiq_n));

    // R10: with no held winner the source register reads zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !hit_cfg && word_hit(bus_addr, OFS_IRQ_SRC)) |-> bus_rdata == '0);

endmodule

// File: tb/intc_bank_tb.sv
`timescale 1ns/1ps
module intc_bank_tb;

    localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_ISRC = 8'h08,
                           A_FSRC = 8'h0C, A_CTRL = 8'h10, A_CFG = 8'h80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n, fiq_n;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pend, m_mask, m_fiq;
    logic [4:0]  m_prio [32];

    always #2.5 clk = ~clk;

    intc_bank u_dut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .fiq_n(fiq_n)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [31:0] p);
        @(negedge clk);
        src_in = p;
        @(negedge clk);
        src_in = '0;
    endtask

    function automatic int exp_win(logic [31:0] c);
        int best = -1;
        int bp = 99;
        for (int i = 0; i < 32; i++)
            if (c[i] && int'(m_prio[i]) < bp) begin
                best = i;
                bp = int'(m_prio[i]);
            end
        return best;
    endfunction

    function automatic logic [31:0] src_val(int w);
        return (w < 0) ? 32'h0 : 32'(w);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_MASK, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(A_PEND, v); chk("R1 pend", v, 32'h0);
        rd(A_ISRC, v); chk("R1 irq src", v, 32'h0);
        rd(A_FSRC, v); chk("R1 fiq src", v, 32'h0);
        rd(A_CFG + 8'd28, v); chk("R1 cfg", v, 32'h0);
        chk("R1 outputs", {30'h0, irq_n, fiq_n}, 32'h3);

        // R2 config word width
        wr(A_CFG + 8'd20, 32'hFFFF_FFFF);
        rd(A_CFG + 8'd20, v); chk("R2 cfg readback", v, 32'h7F);
        wr(A_CFG + 8'd20, 32'h0);

        // R4 level sensing, R8 hold after drop, R9/R10 release
        wr(A_CFG + 8'd12, 32'h10);
        wr(A_MASK, ~32'h8);
        @(negedge clk); src_in = 32'h8;
        idle(2);
        rd(A_PEND, v); chk("R4 level pend set", v, 32'h8);
        rd(A_ISRC, v); chk("R10 irq src level", v, 32'd3);
        chk("R10 irq_n low", {31'h0, irq_n}, 32'h0);
        @(negedge clk); src_in = '0;
        idle(1);
        rd(A_PEND, v); chk("R4 level pend drop", v, 32'h0);
        rd(A_ISRC, v); chk("R8 hold after drop", v, 32'd3);
        wr(A_CTRL, 32'h1); idle(1);
        chk("R9 irq released", {31'h0, irq_n}, 32'h1);
        rd(A_ISRC, v); chk("R10 idle src zero", v, 32'h0);

        // R5 edge latch, R8 freeze against better request, R7 order
        wr(A_CFG + 8'd40, 32'h2A);
        wr(A_CFG + 8'd80, 32'h06);
        wr(A_MASK, ~(32'h400 | 32'h10_0000));
        pulse(32'h400); idle(1);
        rd(A_ISRC, v); chk("R5 edge wins", v, 32'd10);
        rd(A_PEND, v); chk("R5 edge latched", v, 32'h400);
        pulse(32'h10_0000); idle(1);
        rd(A_ISRC, v); chk("R8 frozen winner", v, 32'd10);
        wr(A_CTRL, 32'h1); idle(1);
        rd(A_ISRC, v); chk("R7 better prio next", v, 32'd20);
        rd(A_PEND, v); chk("R9 ack clears edge", v, 32'h10_0000);
        wr(A_CTRL, 32'h1); idle(1);
        chk("R9 empty", {31'h0, irq_n}, 32'h1);

        // R9 independent release of the two outputs
        wr(A_CFG + 8'd48, 32'h0F);
        wr(A_MASK, ~(32'h400 | 32'h1000 | 32'h10_0000));
        pulse(32'h1400); idle(1);
        rd(A_FSRC, v); chk("R7 fiq winner", v, 32'd12);
        rd(A_ISRC, v); chk("R7 irq winner", v, 32'd10);
        wr(A_CTRL, 32'h1); idle(1);
        chk("R9 bit0 only irq", {30'h0, irq_n, fiq_n}, 32'h2);
        rd(A_FSRC, v); chk("R9 fiq kept", v, 32'd12);
        wr(A_CTRL, 32'h2); idle(1);
        chk("R9 bit1 fiq", {31'h0, fiq_n}, 32'h1);

        // R3 masking, R6 pending write
        wr(A_MASK, 32'hFFFF_FFFF);
        pulse(32'h10_0400); idle(1);
        rd(A_PEND, v); chk("R3 masked still pending", v, 32'h10_0400);
        chk("R3 masked no output", {31'h0, irq_n}, 32'h1);
        wr(A_PEND, 32'h10_0000);
        rd(A_PEND, v); chk("R6 and-write", v, 32'h10_0000);
        wr(A_PEND, 32'h0);
        rd(A_PEND, v); chk("R6 clear all", v, 32'h0);

        // R7 tie goes to lower number
        wr(A_CFG + 8'd24, 32'h0A);
        wr(A_CFG + 8'd36, 32'h0A);
        pulse(32'h240);
        wr(A_MASK, ~32'h240); idle(1);
        rd(A_ISRC, v); chk("R7 tie low", v, 32'd6);
        wr(A_CTRL, 32'h1); idle(1);
        rd(A_ISRC, v); chk("R7 tie next", v, 32'd9);
        wr(A_CTRL, 32'h1); idle(1);

        // Random rounds: R2 R3 R5 R7 R9 R10
        for (int r = 0; r < 30; r++) begin
            wr(A_MASK, 32'hFFFF_FFFF);
            wr(A_PEND, 32'h0);
            wr(A_CTRL, 32'h3);
            idle(1);
            for (int i = 0; i < 32; i++) begin
                logic [31:0] w;
                w = $urandom;
                m_prio[i] = w[6:2];
                m_fiq[i]  = w[0];
                wr(A_CFG + 8'(4 * i), {w[31:7], w[6:2], 1'b1, w[0]});
            end
            pat = $urandom;
            pulse(pat);
            m_pend = pat;
            m_mask = $urandom & $urandom & $urandom;
            wr(A_MASK, m_mask);
            idle(1);
            for (int k = 0; k < 34; k++) begin
                int ei, ef;
                ei = exp_win(m_pend & ~m_mask & ~m_fiq);
                ef = exp_win(m_pend & ~m_mask & m_fiq);
                rd(A_ISRC, v); chk("R7 rand irq src", v, src_val(ei));
                rd(A_FSRC, v); chk("R7 rand fiq src", v, src_val(ef));
                chk("R10 rand outputs", {30'h0, irq_n, fiq_n},
                    {30'h0, (ei < 0), (ef < 0)});
                if (ei < 0 && ef < 0) break;
                wr(A_CTRL, 32'h3);
                idle(1);
                if (ei >= 0) m_pend[ei] = 1'b0;
                if (ef >= 0) m_pend[ef] = 1'b0;
            end
            rd(A_PEND, v); chk("R3 rand masked left", v, pat & m_mask);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule